// File: doc/BRIEF.md
# Digit-Serial Multiply-Subtract Unit

This unit performs the inner step of schoolbook long division on multi-word integers. Given one scalar trial quotient digit, it multiplies a divisor vector by that digit and subtracts the product from a window of the partial remainder. It handles one 32-bit digit per cycle, least significant digit first. The multiply carry chain and the subtract borrow chain are fused, so each divisor/remainder pair that goes in produces one updated remainder digit.

A start pulse latches the trial digit and the top index `n`. The unit then accepts `n+1` divisor/remainder pairs through a valid/ready handshake. It returns each new remainder digit one cycle after acceptance. With the last digit it raises a done pulse, which carries a flag. The flag tells the caller that the window went negative and that an add-back correction pass is needed. That correction pass, the estimation of the trial digit and the storage of the remainder all belong to the caller.

Top module: `mulsub_unit`

## Requirements
- R1: While reset is held and after it is released, `inReady`, `outValid`, `doneValid` and `fixupNeeded` are all 0.
- R2: When the unit is idle, a `startPulse` latches `trialDigit` and `digitCount`, and `inReady` is 1 from the next cycle. A `startPulse` while `inReady` is 1 is ignored, and the running operation keeps its trial digit and its digit count.
- R3: A pair is accepted on a clock edge where `inValid` and `inReady` are both 1. The unit then presents `outDigit` with `outValid`=1 in the following cycle and never otherwise. Pairs may be accepted on consecutive cycles.
- R4: For each position the 64-bit product term is divisor digit × trial digit + multiply carry. The low 32 bits are the product digit and the high 32 bits are the multiply carry for the next position. The multiply carry is 0 at position 0.
- R5: Each output digit is the low 32 bits of (bitwise inverse of the product digit) + remainder digit + subtract carry, computed in 33 bits. The subtract carry is 1 at position 0, and afterwards it is bit 32 of the previous sum.
- R6: An operation covers positions 0 through `digitCount`, which is `digitCount`+1 pairs. `inReady` falls right after the last of these pairs is accepted.
- R7: At position `digitCount` the divisor digit input is ignored and treated as 0.
- R8: `doneValid` pulses for one cycle, together with the output for position `digitCount`. `fixupNeeded` at that time is the inverse of the final subtract carry (1 means the window went negative). It then holds until the next accepted start clears it.
- R9: A `startPulse` given in the cycle that `doneValid` is high is accepted. The carries restart cleanly for the new operation, and the finished operation's `fixupNeeded` is still visible in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin an operation (ignored while busy) |
| trialDigit | input | 32 | Scalar trial quotient digit |
| digitCount | input | 8 | Top position index n (n+1 pairs follow) |
| inValid | input | 1 | Divisor/remainder pair is present |
| inReady | output | 1 | Unit can accept a pair |
| divDigit | input | 32 | Divisor digit for the current position |
| remDigit | input | 32 | Remainder digit for the current position |
| outValid | output | 1 | Updated remainder digit is present |
| outDigit | output | 32 | Updated remainder digit |
| doneValid | output | 1 | Final digit of the operation is being presented |
| fixupNeeded | output | 1 | Add-back correction is required |

## Verification
Two events can meet in one cycle: the done pulse of a finishing operation, and the start of the next operation. The bench holds `startPulse` high exactly in the cycle where `doneValid` shows a negative result. It checks that the flag is still 1 in that cycle and that `inReady` returns on the next cycle. It then feeds the new operation's digits and compares them against a model with fresh carries, which catches any carry or flag that leaks across the boundary. A second overlap, a start arriving while digits are still being accepted, is provoked mid-operation and judged by the digit count and the results of the running operation.

// File: rtl/mulsub_pkg.sv
package mulsub_pkg;
  // Strobes the sequencer hands to the datapath each cycle
  typedef struct packed {
    logic loadOp;     // accept a new operation: latch trial digit, reset carries
    logic stepDigit;  // a digit pair is accepted this cycle
    logic lastDigit;  // the accepted pair is the top position
    logic topPos;     // current position is the top one (divisor forced to 0)
  } seqStrobe_t;
endpackage

// File: rtl/mulsub_cell.sv
// Combinational fused multiply-subtract for one digit position
module mulsub_cell #(
  parameter int DIGIT_W = 32
) (
  input  logic [DIGIT_W-1:0] divIn,
  input  logic [DIGIT_W-1:0] trialIn,
  input  logic [DIGIT_W-1:0] mulCarryIn,
  input  logic [DIGIT_W-1:0] remIn,
  input  logic               subCarryIn,
  output logic [DIGIT_W-1:0] mulCarryOut,
  output logic [DIGIT_W-1:0] diffOut,
  output logic               subCarryOut
);
  localparam int WIDE_W = 2 * DIGIT_W;
  localparam int SUM_W  = DIGIT_W + 1;

  logic [WIDE_W-1:0]  term;
  logic [DIGIT_W-1:0] prodLo;
  logic [SUM_W-1:0]   sum;

  always_comb begin
    term        = WIDE_W'(divIn) * WIDE_W'(trialIn) + WIDE_W'(mulCarryIn);
    prodLo      = term[DIGIT_W-1:0];
    mulCarryOut = term[WIDE_W-1:DIGIT_W];
    sum         = {1'b0, ~prodLo} + {1'b0, remIn} + SUM_W'(subCarryIn);
    diffOut     = sum[DIGIT_W-1:0];
    subCarryOut = sum[DIGIT_W];
  end
endmodule

// File: rtl/mulsub_ctrl.sv
// Sequencer: position counter, busy state and strobes
module mulsub_ctrl
  import mulsub_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] digitCount,
  input  logic             inValid,
  output logic             inReady,
  output seqStrobe_t       strobe
);
  logic             busy;
  logic [CNT_W-1:0] posIdx;
  logic [CNT_W-1:0] topIdx;
  logic             atTop;

  always_comb begin
    atTop            = (posIdx == topIdx);
    inReady          = busy;
    strobe.loadOp    = startPulse && !busy;
    strobe.stepDigit = inValid && busy;
    strobe.lastDigit = inValid && busy && atTop;
    strobe.topPos    = busy && atTop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      posIdx <= '0;
      topIdx <= '0;
    end else if (strobe.loadOp) begin
      busy   <= 1'b1;
      posIdx <= '0;
      topIdx <= digitCount;
    end else if (strobe.stepDigit) begin
      posIdx <= posIdx + 1'b1;
      if (strobe.lastDigit) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mulsub_dp.sv
// Datapath: trial digit, fused carry chains, output register
module mulsub_dp
  import mulsub_pkg::*;
#(
  parameter int DIGIT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [DIGIT_W-1:0] trialDigit,
  input  logic [DIGIT_W-1:0] divDigit,
  input  logic [DIGIT_W-1:0] remDigit,
  output logic               outValid,
  output logic [DIGIT_W-1:0] outDigit,
  output logic               doneValid,
  output logic               fixupNeeded
);
  logic [DIGIT_W-1:0] trialReg;
  logic [DIGIT_W-1:0] mulCarry;
  logic               subCarry;
  logic [DIGIT_W-1:0] divEff;
  logic [DIGIT_W-1:0] nextMulCarry;
  logic [DIGIT_W-1:0] nextDiff;
  logic               nextSubCarry;

  assign divEff = strobe.topPos ? '0 : divDigit;

  mulsub_cell #(.DIGIT_W(DIGIT_W)) u_cell (
    .divIn      (divEff),
    .trialIn    (trialReg),
    .mulCarryIn (mulCarry),
    .remIn      (remDigit),
    .subCarryIn (subCarry),
    .mulCarryOut(nextMulCarry),
    .diffOut    (nextDiff),
    .subCarryOut(nextSubCarry)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trialReg    <= '0;
      mulCarry    <= '0;
      subCarry    <= 1'b1;
      outValid    <= 1'b0;
      outDigit    <= '0;
      doneValid   <= 1'b0;
      fixupNeeded <= 1'b0;
    end else begin
      outValid  <= strobe.stepDigit;
      doneValid <= strobe.lastDigit;
      if (strobe.loadOp) begin
        trialReg    <= trialDigit;
        mulCarry    <= '0;
        subCarry    <= 1'b1;
        fixupNeeded <= 1'b0;
      end else if (strobe.stepDigit) begin
        outDigit <= nextDiff;
        mulCarry <= nextMulCarry;
        subCarry <= nextSubCarry;
        if (strobe.lastDigit) fixupNeeded <= ~nextSubCarry;
      end
    end
  end
endmodule

// File: rtl/mulsub_unit.sv
// Thin top: sequencer plus datapath
module mulsub_unit
  import mulsub_pkg::*;
#(
  parameter int DIGIT_W = 32,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [DIGIT_W-1:0] trialDigit,
  input  logic [CNT_W-1:0]   digitCount,
  input  logic               inValid,
  output logic               inReady,
  input  logic [DIGIT_W-1:0] divDigit,
  input  logic [DIGIT_W-1:0] remDigit,
  output logic               outValid,
  output logic [DIGIT_W-1:0] outDigit,
  output logic               doneValid,
  output logic               fixupNeeded
);
  seqStrobe_t strobe;

  mulsub_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .digitCount(digitCount),
    .inValid   (inValid),
    .inReady   (inReady),
    .strobe    (strobe)
  );

  mulsub_dp #(.DIGIT_W(DIGIT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .trialDigit (trialDigit),
    .divDigit   (divDigit),
    .remDigit   (remDigit),
    .outValid   (outValid),
    .outDigit   (outDigit),
    .doneValid  (doneValid),
    .fixupNeeded(fixupNeeded)
  );
endmodule

// File: rtl/mulsub_chk.sv
module mulsub_chk (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic doneValid,
  input logic fixupNeeded
);
  a_r3_out_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  a_r3_no_spurious_out: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !outValid);

  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !inReady) |=> inReady);

  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> inReady);

  a_r8_done_with_out: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> outValid);

  a_r6_done_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !inReady);

  a_r8_fixup_set_at_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fixupNeeded) |-> doneValid);
endmodule

bind mulsub_unit mulsub_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .inValid    (inValid),
  .inReady    (inReady),
  .outValid   (outValid),
  .doneValid  (doneValid),
  .fixupNeeded(fixupNeeded)
);

// File: tb/mulsub_unit_bench.sv
`timescale 1ns/1ps
module mulsub_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] trialDigit = '0;
  logic [7:0]  digitCount = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] divDigit = '0;
  logic [31:0] remDigit = '0;
  logic        outValid;
  logic [31:0] outDigit;
  logic        doneValid;
  logic        fixupNeeded;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mulsub_unit u_mulsub_unit (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .trialDigit(trialDigit),
    .digitCount(digitCount), .inValid(inValid), .inReady(inReady),
    .divDigit(divDigit), .remDigit(remDigit), .outValid(outValid),
    .outDigit(outDigit), .doneValid(doneValid), .fixupNeeded(fixupNeeded)
  );

  // Stimulus table: top index, trial digit, divisor and remainder digits, bubble flag
  localparam int NVEC = 4;
  localparam int         V_N   [NVEC] = '{3, 2, 3, 1};
  localparam logic [31:0] V_TR [NVEC] = '{32'h0000_0007, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001};
  localparam logic [3:0][31:0] V_DIV [NVEC] = '{
    {32'hDEAD_BEEF, 32'h0000_0003, 32'h0000_0002, 32'h0000_0009},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h5555_5555, 32'h8765_4321, 32'h0F0F_0F0F, 32'hFFFF_0000},
    {32'h0000_0000, 32'h0000_0000, 32'hAAAA_AAAA, 32'h7FFF_FFFF}};
  localparam logic [3:0][31:0] V_REM [NVEC] = '{
    {32'h0000_0001, 32'h0000_0020, 32'h0000_0030, 32'h0000_0100},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h0000_0000, 32'h0000_0001, 32'h2222_2222, 32'h1111_1111},
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}};
  localparam bit V_BUB [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1};

  // Output monitor, sampled away from the active edge
  logic [31:0] cap [16];
  int capCnt = 0;
  int doneCnt = 0;
  logic doneFix = 1'b0;
  always @(negedge clk) begin
    if (outValid && capCnt < 16) begin
      cap[capCnt] = outDigit;
      capCnt = capCnt + 1;
    end
    if (doneValid) begin
      doneCnt = doneCnt + 1;
      doneFix = fixupNeeded;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference from the requirements (R4, R5, R7, R8)
  task automatic refOp(input int n, input logic [31:0] tr, input logic [3:0][31:0] dv,
                       input logic [3:0][31:0] rv, output logic [3:0][31:0] ex, output logic fx);
    logic [63:0] term;
    logic [32:0] sum;
    logic [31:0] mc;
    logic        sc;
    mc = '0; sc = 1'b1; ex = '0;
    for (int i = 0; i <= n; i++) begin
      term  = {32'd0, (i == n) ? 32'd0 : dv[i]} * {32'd0, tr} + {32'd0, mc};
      mc    = term[63:32];
      sum   = {1'b0, ~term[31:0]} + {1'b0, rv[i]} + {32'd0, sc};
      sc    = sum[32];
      ex[i] = sum[31:0];
    end
    fx = ~sc;
  endtask

  // Runs one operation from a negedge; returns at a negedge
  task automatic runOp(input int n, input logic [31:0] tr, input logic [3:0][31:0] dv,
                       input logic [3:0][31:0] rv, input bit bubble, input string tag);
    logic [3:0][31:0] ex;
    logic fx;
    capCnt = 0; doneCnt = 0;
    startPulse = 1'b1; trialDigit = tr; digitCount = 8'(n);
    @(negedge clk);
    startPulse = 1'b0;
    check({tag, " R2 ready after start"}, 32'(inReady), 32'd1);
    for (int i = 0; i <= n; i++) begin
      inValid = 1'b1; divDigit = dv[i]; remDigit = rv[i];
      @(negedge clk);
      if (bubble) begin
        inValid = 1'b0;
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    check({tag, " R6 ready drops after last"}, 32'(inReady), 32'd0);
    @(negedge clk);
    @(negedge clk);
    refOp(n, tr, dv, rv, ex, fx);
    check({tag, " R6 digit count"}, 32'(capCnt), 32'(n + 1));
    for (int i = 0; i <= n; i++)
      check($sformatf("%s R5 digit %0d", tag, i), cap[i], ex[i]);
    check({tag, " R8 one done pulse"}, 32'(doneCnt), 32'd1);
    check({tag, " R8 fixup flag"}, 32'(doneFix), 32'(fx));
    check({tag, " R8 fixup held"}, 32'(fixupNeeded), 32'(fx));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [3:0][31:0] dv;
    logic [3:0][31:0] rv;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(inReady), 32'd0);
    check("R1 outValid in reset", 32'(outValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(inReady), 32'd0);
    check("R1 done after reset", 32'(doneValid), 32'd0);
    check("R1 fixup after reset", 32'(fixupNeeded), 32'd0);

    // R3: pair offered while idle is not accepted
    inValid = 1'b1; divDigit = 32'h5; remDigit = 32'h9;
    @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check("R3 no output while idle", 32'(capCnt), 32'd0);

    // Table-driven operations (R4 R5 R6 R7 R8)
    for (int v = 0; v < NVEC; v++)
      runOp(V_N[v], V_TR[v], V_DIV[v], V_REM[v], V_BUB[v], $sformatf("vec%0d", v));

    // R4: full-range multiply carry; R7: supplied top divisor is ignored
    dv = {32'h0, 32'h0, 32'h1357_9BDF, 32'hFFFF_FFFF};
    rv = {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_0001};
    capCnt = 0;
    runOp(1, 32'hFFFF_FFFF, dv, rv, 1'b0, "carry");
    check("R4 carry digit0", cap[0], 32'h0000_0000);
    check("R7 top divisor ignored digit1", cap[1], 32'h0000_0001);

    // R2: start while busy is ignored (would set trial 7 and n=0)
    dv = {32'h0, 32'h0, 32'h0, 32'h5};
    rv = {32'h0, 32'h0, 32'h0, 32'd20};
    capCnt = 0; doneCnt = 0;
    startPulse = 1'b1; trialDigit = 32'd2; digitCount = 8'd1;
    @(negedge clk);
    trialDigit = 32'd7; digitCount = 8'd0;   // startPulse still high: busy, ignored
    inValid = 1'b1; divDigit = dv[0]; remDigit = rv[0];
    @(negedge clk);
    startPulse = 1'b0;
    check("R2 busy start keeps count", 32'(inReady), 32'd1);
    divDigit = 32'h0; remDigit = 32'h0;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 busy start keeps trial", cap[0], 32'd10);
    check("R2 second digit", cap[1], 32'd0);
    check("R2 two digits", 32'(capCnt), 32'd2);
    check("R8 no fixup positive", 32'(fixupNeeded), 32'd0);

    // R9: negative op (trial 3, div 5, rem 10), start next op in the done cycle
    startPulse = 1'b1; trialDigit = 32'd3; digitCount = 8'd1;
    @(negedge clk);
    startPulse = 1'b0;
    inValid = 1'b1; divDigit = 32'd5; remDigit = 32'd10;
    @(negedge clk);
    divDigit = 32'd0; remDigit = 32'd0;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 done in overlap cycle", 32'(doneValid), 32'd1);
    check("R9 fixup visible in done cycle", 32'(fixupNeeded), 32'd1);
    check("R9 last digit negative", outDigit, 32'hFFFF_FFFF);
    startPulse = 1'b1; trialDigit = 32'd2; digitCount = 8'd1;
    @(negedge clk);
    startPulse = 1'b0;
    check("R9 ready after overlapped start", 32'(inReady), 32'd1);
    check("R9 fixup cleared by start", 32'(fixupNeeded), 32'd0);
    inValid = 1'b1; divDigit = 32'd5; remDigit = 32'd20;
    @(negedge clk);
    divDigit = 32'd0; remDigit = 32'd0;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 fresh carries digit1", outDigit, 32'd0);
    check("R9 fresh op no fixup", 32'(fixupNeeded), 32'd0);
    @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule